// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command packets held in a 2 MB word-addressed main memory. Each packet begins with a header word. The header's top byte gives how many payload words follow it, and its low 24 bits give the address of the next header. After a start strobe the walker reads each header and streams that packet's payload words, in memory order, to a downstream sink over a valid/ready channel. It then moves to the next address, and it stops when an address has bit 23 set. For each node it adds a fixed charge to a cost estimate, plus a charge that depends on the payload length. The final total goes out with a one-cycle done pulse.

A malformed chain can point back into itself. To guard against this, the walker counts nodes. Once the count passes a threshold (parameter `LOOP_LIMIT`), it writes bit 23 into every header it visits. A cycle therefore runs into a tagged header and ends. When the walk is over, the walker follows the tagged region again from an address it saved and removes the tags, so the memory image is restored. The payload words are not interpreted.

Top module: `ll_chain_walker`

## Requirements
- R1: After reset, done, out_valid, mem_rd and mem_wr are 0. A start pulse while idle captures start_addr[23:0]. If bit 23 of that address is set, the walk ends with no memory access and done reports a cost of 0. A start pulse while a walk is in progress is ignored.
- R2: A header word holds the payload length in bits 31:24 and the next address in bits 23:0. The walk continues until the address to visit has bit 23 set.
- R3: An address selects the memory word address[20:2], so bits 23:21 and 1:0 are ignored. Payload word i (i = 1..length) of a node is read from header index + i, modulo 2^19.
- R4: Payload words are sent on out_data in chain order and memory order. A node of length 0 sends nothing and the walk still moves on to its next address.
- R5: The cost is the sum over all visited nodes of 10, plus 5 + length when the length is nonzero. It is presented on cost while done is high.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R7: Nodes are numbered from 0 in visit order. At node LOOP_LIMIT the next address is saved. Every node numbered above LOOP_LIMIT has its header written back with bit 23 set, after that header has been read.
- R8: If an address was saved and the total node count N exceeds LOOP_LIMIT+2, cleanup starts at the saved address and walks N-LOOP_LIMIT-2 headers. For each, it reads the header, writes it back with bit 23 cleared, and follows the header's bits 20:0. Otherwise cleanup performs no write.
- R9: A cyclic chain ends, and afterwards every header in it holds its original value.
- R10: done is high for exactly one cycle. It comes after the last payload word and the last cleanup write.
- R11: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, taken only while idle |
| start_addr | input | 24 | Address of the first header |
| mem_rd | output | 1 | Memory read request; data is returned one cycle later |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 19 | Memory word index |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the cycle after mem_rd |
| out_valid | output | 1 | Payload word available |
| out_ready | input | 1 | Sink accepts the payload word |
| out_data | output | 32 | Payload word |
| done | output | 1 | One-cycle end-of-walk pulse |
| cost | output | COST_W | Accumulated cost estimate, final while done is high |

## Verification
Most internal errors in this walker surface at the ports quickly. A wrong length decode or a wrong payload pointer sends a wrong word, or the wrong number of words, to the sink within a few cycles of the header read. A cost slip shows at the next done pulse. A mistake in the node counter or the saved address does not disturb the payload stream. It shows only after the walk, either as the wrong number of memory writes or as a header left tagged. For that reason the bench counts memory traffic per walk and reads the chain back afterwards.

// File: rtl/ll_walk_pkg.sv
package ll_walk_pkg;

  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned IDX_W    = 19;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LEN_W    = 8;
  localparam int unsigned TERM_BIT = 23;
  localparam int unsigned SPAN_W   = 21;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHECK,
    S_HDR_WAIT,
    S_TAG,
    S_PAY_RD,
    S_PAY_WAIT,
    S_PAY_OUT,
    S_ADV,
    S_CL_INIT,
    S_CL_RD,
    S_CL_WAIT,
    S_DONE
  } walk_state_e;

  // byte address to memory word index (address bits 20:2)
  function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W+1:2];
  endfunction

  function automatic logic [LEN_W-1:0] hdr_len(input logic [WORD_W-1:0] h);
    return h[WORD_W-1 -: LEN_W];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_next(input logic [WORD_W-1:0] h);
    return h[ADDR_W-1:0];
  endfunction

  function automatic logic is_term(input logic [ADDR_W-1:0] a);
    return a[TERM_BIT];
  endfunction

  // per-node charge: 10, plus 5 + length for a non-empty node
  function automatic logic [15:0] node_cost(input logic [LEN_W-1:0] len);
    logic [15:0] c;
    c = 16'd10;
    if (len != '0) c = c + 16'd5 + {{(16-LEN_W){1'b0}}, len};
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] hdr_tag(input logic [WORD_W-1:0] h);
    logic [WORD_W-1:0] r;
    r = h;
    r[TERM_BIT] = 1'b1;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] hdr_untag(input logic [WORD_W-1:0] h);
    logic [WORD_W-1:0] r;
    r = h;
    r[TERM_BIT] = 1'b0;
    return r;
  endfunction

  // link followed during cleanup keeps only the low 21 address bits
  function automatic logic [ADDR_W-1:0] span_link(input logic [WORD_W-1:0] h);
    return {{(ADDR_W-SPAN_W){1'b0}}, h[SPAN_W-1:0]};
  endfunction

endpackage

// File: rtl/ll_cost_acc.sv
module ll_cost_acc
  import ll_walk_pkg::*;
#(
  parameter int unsigned COST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add_en,
  input  logic [LEN_W-1:0]  len,
  output logic [COST_W-1:0] total
);

  logic [COST_W-1:0] charge;
  assign charge = COST_W'(node_cost(len));

  always_ff @(posedge clk) begin
    if (!rst_n)      total <= '0;
    else if (clear)  total <= '0;
    else if (add_en) total <= total + charge;
  end

endmodule

// File: rtl/ll_loop_guard.sv
module ll_loop_guard
  import ll_walk_pkg::*;
#(
  parameter int unsigned LOOP_LIMIT = 8192,
  parameter int unsigned CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hdr_seen,
  input  logic              node_step,
  input  logic [ADDR_W-1:0] next_addr,
  output logic [CNT_W-1:0]  node_cnt,
  output logic              tag_node,
  output logic [ADDR_W-1:0] mark_addr,
  output logic              mark_valid,
  output logic              clean_due,
  output logic [CNT_W-1:0]  clean_cnt
);

  localparam logic [CNT_W-1:0] LIM  = CNT_W'(LOOP_LIMIT);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'(LOOP_LIMIT + 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_cnt   <= '0;
      mark_addr  <= '0;
      mark_valid <= 1'b0;
    end else if (clear) begin
      node_cnt   <= '0;
      mark_addr  <= '0;
      mark_valid <= 1'b0;
    end else begin
      if (hdr_seen && node_cnt == LIM) begin
        mark_addr  <= next_addr;
        mark_valid <= 1'b1;
      end
      if (node_step) node_cnt <= node_cnt + 1'b1;
    end
  end

  assign tag_node  = node_cnt > LIM;
  assign clean_due = mark_valid && (node_cnt > LIM2);
  assign clean_cnt = node_cnt - LIM2;

endmodule

// File: rtl/ll_payload_slot.sv
module ll_payload_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         fire
);

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (fire) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ll_chain_walker.sv
module ll_chain_walker
  import ll_walk_pkg::*;
#(
  parameter int unsigned LOOP_LIMIT = 8192,
  parameter int unsigned COST_W     = 32,
  parameter int unsigned CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       start_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [18:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              done,
  output logic [COST_W-1:0] cost
);

  walk_state_e state, state_nx;

  logic [ADDR_W-1:0] cur_addr;
  logic [WORD_W-1:0] hdr_q;
  logic [IDX_W-1:0]  hdr_idx;
  logic [IDX_W-1:0]  pay_ptr;
  logic [LEN_W-1:0]  pay_left;
  logic [ADDR_W-1:0] next_q;
  logic [ADDR_W-1:0] cl_addr;
  logic [CNT_W-1:0]  cl_left;

  // named internal events
  logic ev_start, ev_hdr_cap, ev_tag_wr, ev_clean_wr, ev_walk_end, ev_node_step;
  logic pay_fire;

  logic [CNT_W-1:0]  node_cnt, clean_cnt;
  logic              tag_node, mark_valid, clean_due;
  logic [ADDR_W-1:0] mark_addr;
  logic [LEN_W-1:0]  rd_len;

  assign rd_len       = hdr_len(mem_rdata);
  assign ev_start     = (state == S_IDLE) && start;
  assign ev_hdr_cap   = (state == S_HDR_WAIT);
  assign ev_tag_wr    = (state == S_TAG);
  assign ev_clean_wr  = (state == S_CL_WAIT);
  assign ev_walk_end  = (state == S_CHECK) && is_term(cur_addr);
  assign ev_node_step = (state == S_ADV);

  ll_cost_acc #(.COST_W(COST_W)) u_cost (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ev_start),
    .add_en (ev_hdr_cap),
    .len    (rd_len),
    .total  (cost)
  );

  ll_loop_guard #(.LOOP_LIMIT(LOOP_LIMIT), .CNT_W(CNT_W)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (ev_start),
    .hdr_seen   (ev_hdr_cap),
    .node_step  (ev_node_step),
    .next_addr  (hdr_next(mem_rdata)),
    .node_cnt   (node_cnt),
    .tag_node   (tag_node),
    .mark_addr  (mark_addr),
    .mark_valid (mark_valid),
    .clean_due  (clean_due),
    .clean_cnt  (clean_cnt)
  );

  ll_payload_slot #(.W(WORD_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (state == S_PAY_WAIT),
    .din       (mem_rdata),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .fire      (pay_fire)
  );

  // next-state logic
  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:     if (start) state_nx = S_CHECK;
      S_CHECK:    state_nx = is_term(cur_addr) ? S_CL_INIT : S_HDR_WAIT;
      S_HDR_WAIT: begin
        if (tag_node)          state_nx = S_TAG;
        else if (rd_len != '0) state_nx = S_PAY_RD;
        else                   state_nx = S_ADV;
      end
      S_TAG:      state_nx = (hdr_len(hdr_q) != '0) ? S_PAY_RD : S_ADV;
      S_PAY_RD:   state_nx = S_PAY_WAIT;
      S_PAY_WAIT: state_nx = S_PAY_OUT;
      S_PAY_OUT:  if (pay_fire) state_nx = (pay_left == LEN_W'(1)) ? S_ADV : S_PAY_RD;
      S_ADV:      state_nx = S_CHECK;
      S_CL_INIT:  state_nx = clean_due ? S_CL_RD : S_DONE;
      S_CL_RD:    state_nx = S_CL_WAIT;
      S_CL_WAIT:  state_nx = (cl_left == CNT_W'(1)) ? S_DONE : S_CL_RD;
      S_DONE:     state_nx = S_IDLE;
      default:    state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  // datapath registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      hdr_q    <= '0;
      hdr_idx  <= '0;
      pay_ptr  <= '0;
      pay_left <= '0;
      next_q   <= '0;
      cl_addr  <= '0;
      cl_left  <= '0;
    end else begin
      unique case (state)
        S_IDLE:     if (start) cur_addr <= start_addr;
        S_CHECK:    hdr_idx <= word_index(cur_addr);
        S_HDR_WAIT: begin
          hdr_q    <= mem_rdata;
          pay_left <= rd_len;
          pay_ptr  <= hdr_idx + 1'b1;
          next_q   <= hdr_next(mem_rdata);
        end
        S_PAY_OUT: if (pay_fire) begin
          pay_ptr  <= pay_ptr + 1'b1;
          pay_left <= pay_left - 1'b1;
        end
        S_ADV:     cur_addr <= next_q;
        S_CL_INIT: if (clean_due) begin
          cl_left <= clean_cnt;
          cl_addr <= mark_addr;
        end
        S_CL_WAIT: begin
          cl_addr <= span_link(mem_rdata);
          cl_left <= cl_left - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // memory port
  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_CHECK: begin
        mem_rd   = !is_term(cur_addr);
        mem_addr = word_index(cur_addr);
      end
      S_TAG: begin
        mem_wr    = 1'b1;
        mem_addr  = hdr_idx;
        mem_wdata = hdr_tag(hdr_q);
      end
      S_PAY_RD: begin
        mem_rd   = 1'b1;
        mem_addr = pay_ptr;
      end
      S_CL_RD: begin
        mem_rd   = 1'b1;
        mem_addr = word_index(cl_addr);
      end
      S_CL_WAIT: begin
        mem_wr    = 1'b1;
        mem_addr  = word_index(cl_addr);
        mem_wdata = hdr_untag(mem_rdata);
      end
      default: ;
    endcase
  end

  assign done = (state == S_DONE);

endmodule

// File: rtl/ll_chain_walker_chk.sv
module ll_chain_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] mem_wdata,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        done,
  input logic        ev_tag_wr,
  input logic        ev_clean_wr,
  input logic        ev_walk_end
);

  // R6
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  tag_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tag_wr |-> mem_wr && mem_wdata[23]);

  // R8
  clean_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clean_wr |-> mem_wr && !mem_wdata[23]);

  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R10
  end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_walk_end |-> !out_valid && !done);

endmodule

bind ll_chain_walker ll_chain_walker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_wdata   (mem_wdata),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .done        (done),
  .ev_tag_wr   (ev_tag_wr),
  .ev_clean_wr (ev_clean_wr),
  .ev_walk_end (ev_walk_end)
);

// File: tb/test_ll_chain_walker.sv
module test_ll_chain_walker;

  localparam int LIMIT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        mem_rd, mem_wr;
  logic [18:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        done;
  logic [31:0] cost;

  always #5 clk = ~clk;

  ll_chain_walker #(.LOOP_LIMIT(LIMIT), .COST_W(32), .CNT_W(32)) i_ll_chain_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done), .cost(cost)
  );

  // memory model: one-cycle read latency
  logic [31:0] mem [int];
  logic        tb_we = 1'b0;
  logic [18:0] tb_waddr = '0;
  logic [31:0] tb_wdata = '0;
  int rd_cnt = 0;
  int wr_cnt = 0;

  always @(posedge clk) begin
    if (tb_we) mem[int'(tb_waddr)] = tb_wdata;
    else if (mem_wr) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd) begin
      mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 32'h0;
      rd_cnt <= rd_cnt + 1;
    end
  end

  // scoreboard monitor, ready pattern and watchdog
  logic [31:0] exp_q[$];
  int mon_checks = 0, mon_errs = 0;
  int ready_mode = 0;
  int ph = 0;
  int cyc = 0;
  int checks = 0, errs = 0;

  always @(negedge clk) begin
    ph++;
    cyc++;
    case (ready_mode)
      1:       out_ready = (ph % 3) != 0;
      2:       out_ready = (ph % 5) == 0;
      default: out_ready = 1'b1;
    endcase
    if (rst_n && out_valid && out_ready) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_errs++;
        $display("FAIL R4: payload %h sent, expected none", out_data);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (out_data !== e) begin
          mon_errs++;
          $display("FAIL R4: payload %h, expected %h", out_data, e);
        end
      end
    end
    if (cyc > 150000) begin
      mon_errs++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errs + mon_errs, checks + mon_checks + 1);
      $finish;
    end
  end

  function automatic logic [31:0] hdr(input logic [7:0] len, input logic [23:0] nxt);
    return {len, nxt};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_word(input logic [18:0] idx, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1;
    tb_waddr = idx;
    tb_wdata = d;
  endtask

  task automatic put_end();
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic run_walk(input logic [23:0] a, input bit poke, output logic [31:0] c);
    int n;
    @(negedge clk);
    start = 1'b1;
    start_addr = a;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      start = 1'b1;
      start_addr = 24'h800000;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R10", "done seen", 32'(done), 32'd1);
    c = cost;
    chk(exp_q.size() == 0, "R4", "payload words left over", exp_q.size(), 0);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic push_abc();
    exp_q.push_back(32'hA0000001);
    exp_q.push_back(32'hA0000002);
    exp_q.push_back(32'hC0000001);
    exp_q.push_back(32'hC0000002);
    exp_q.push_back(32'hC0000003);
  endtask

  task automatic build_linear(input logic [23:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      logic [23:0] a;
      logic [23:0] nx;
      a  = base + 24'(16 * i);
      nx = (i == n - 1) ? 24'h800000 : base + 24'(16 * (i + 1));
      put_word(a[20:2], hdr(8'd0, nx));
    end
  endtask

  task automatic check_linear(input logic [23:0] base, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [23:0] a;
      logic [23:0] nx;
      a  = base + 24'(16 * i);
      nx = (i == n - 1) ? 24'h800000 : base + 24'(16 * (i + 1));
      chk(mem[int'(a[20:2])] === hdr(8'd0, nx), req, "header restored",
          mem[int'(a[20:2])], hdr(8'd0, nx));
    end
  endtask

  initial begin
    logic [31:0] c;
    int r0, w0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !out_valid && !mem_rd && !mem_wr, "R1", "outputs idle after reset",
        {28'd0, done, out_valid, mem_rd, mem_wr}, 32'd0);

    // memory image
    put_word(19'h00400, hdr(8'd2, 24'h002000));
    put_word(19'h00401, 32'hA0000001);
    put_word(19'h00402, 32'hA0000002);
    put_word(19'h00800, hdr(8'd0, 24'h003000));
    put_word(19'h00C00, hdr(8'd3, 24'h800000));
    put_word(19'h00C01, 32'hC0000001);
    put_word(19'h00C02, 32'hC0000002);
    put_word(19'h00C03, 32'hC0000003);
    put_word(19'h01000, hdr(8'd1, 24'h403000));
    put_word(19'h01001, 32'hD0000001);
    put_word(19'h7FFFF, hdr(8'd2, 24'h800000));
    put_word(19'h00000, 32'hE0000000);
    put_word(19'h00001, 32'hE0000001);
    put_word(19'h04000, hdr(8'd1, 24'h010100));
    put_word(19'h04001, 32'h5A5A0001);
    put_word(19'h04040, hdr(8'd0, 24'h010000));
    build_linear(24'h020000, 11);
    build_linear(24'h030000, 10);
    build_linear(24'h040000, 9);
    put_end();

    // R1: terminating start address, no memory access
    r0 = rd_cnt;
    run_walk(24'h8ABCDE, 1'b0, c);
    chk(c == 32'd0, "R1", "cost for empty walk", c, 32'd0);
    chk(rd_cnt == r0, "R1", "reads for empty walk", rd_cnt - r0, 0);

    // R2 R4 R5: three-node chain, zero-length middle node, start ignored while busy
    push_abc();
    r0 = rd_cnt; w0 = wr_cnt;
    run_walk(24'h001000, 1'b1, c);
    chk(c == 32'd45, "R5", "cost of three-node chain", c, 32'd45);
    chk(rd_cnt - r0 == 8, "R2", "reads of three-node chain", rd_cnt - r0, 8);
    chk(wr_cnt == w0, "R7", "no writes below limit", wr_cnt - w0, 0);

    // R3: high address bits ignored on start and on links
    push_abc();
    run_walk(24'h601000, 1'b0, c);
    chk(c == 32'd45, "R3", "masked start address cost", c, 32'd45);
    exp_q.push_back(32'hD0000001);
    exp_q.push_back(32'hC0000001);
    exp_q.push_back(32'hC0000002);
    exp_q.push_back(32'hC0000003);
    run_walk(24'h004000, 1'b0, c);
    chk(c == 32'd34, "R3", "masked link address cost", c, 32'd34);

    // R3: payload index wraps at the top of memory
    exp_q.push_back(32'hE0000000);
    exp_q.push_back(32'hE0000001);
    run_walk(24'h1FFFFC, 1'b0, c);
    chk(c == 32'd17, "R3", "wrapping node cost", c, 32'd17);

    // R6: back-pressure patterns
    ready_mode = 1;
    push_abc();
    run_walk(24'h001000, 1'b0, c);
    chk(c == 32'd45, "R6", "cost under light back-pressure", c, 32'd45);
    ready_mode = 2;
    push_abc();
    run_walk(24'h001000, 1'b0, c);
    chk(c == 32'd45, "R6", "cost under heavy back-pressure", c, 32'd45);
    ready_mode = 0;

    // R9: two-node cycle, 12 visits, 3 tag writes, 2 cleanup writes
    for (int i = 0; i < 6; i++) exp_q.push_back(32'h5A5A0001);
    r0 = rd_cnt; w0 = wr_cnt;
    run_walk(24'h010000, 1'b0, c);
    chk(c == 32'd156, "R9", "cycle cost", c, 32'd156);
    chk(wr_cnt - w0 == 5, "R9", "cycle writes", wr_cnt - w0, 5);
    chk(rd_cnt - r0 == 20, "R8", "cycle reads", rd_cnt - r0, 20);
    chk(mem[32'h04000] === hdr(8'd1, 24'h010100), "R9", "node A restored",
        mem[32'h04000], hdr(8'd1, 24'h010100));
    chk(mem[32'h04040] === hdr(8'd0, 24'h010000), "R9", "node B restored",
        mem[32'h04040], hdr(8'd0, 24'h010000));

    // R8: 11 linear nodes: 2 tags + 1 cleanup
    r0 = rd_cnt; w0 = wr_cnt;
    run_walk(24'h020000, 1'b0, c);
    chk(c == 32'd110, "R5", "eleven-node cost", c, 32'd110);
    chk(wr_cnt - w0 == 3, "R8", "eleven-node writes", wr_cnt - w0, 3);
    chk(rd_cnt - r0 == 12, "R8", "eleven-node reads", rd_cnt - r0, 12);
    check_linear(24'h020000, 11, "R8");

    // R8: 10 nodes: one tag, no cleanup
    w0 = wr_cnt;
    run_walk(24'h030000, 1'b0, c);
    chk(c == 32'd100, "R5", "ten-node cost", c, 32'd100);
    chk(wr_cnt - w0 == 1, "R8", "ten-node writes", wr_cnt - w0, 1);
    check_linear(24'h030000, 10, "R8");

    // R7: 9 nodes: address saved, nothing tagged
    w0 = wr_cnt;
    run_walk(24'h040000, 1'b0, c);
    chk(c == 32'd90, "R7", "nine-node cost", c, 32'd90);
    chk(wr_cnt - w0 == 0, "R7", "nine-node writes", wr_cnt - w0, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs + mon_errs, checks + mon_checks);
    $finish;
  end

endmodule